// File: doc/BRIEF.md
# Trap Entry Commit Unit

This block performs the architectural state changes a processor makes when it enters a trap. A trap request arrives with the kind of event (synchronous exception or asynchronous interrupt), a cause number, the faulting address, the current program counter, the current privilege and the current status bits. The unit chooses whether the supervisor or the machine level handles the trap. The choice uses the interrupt or exception delegation mask, qualified by the current privilege. It then commits the new status bits, the cause, return-address and trap-value registers of the chosen level, the handler address and the new privilege in one clock edge. A one-cycle `done` pulse follows.

Trap requests use a valid/ready handshake. A request is taken on a rising edge where `trap_valid` and `trap_ready` are both high. The unit drops `trap_ready` for exactly the cycle in which `done` is high, so it accepts at most one trap every two cycles. A requester that sees `trap_ready` low must hold `trap_valid` and all request fields unchanged until the request is taken.

A small combinational helper is also included. It turns an address-translation failure into the exception cause to report: a page fault when translation was active and the failure was not a protection violation, and an access fault in every other case, with a separate code for fetch, load and store.

Top module: `trap_entry_seq`

## Requirements
- R1: A trap is taken on a rising edge with `trap_valid` and `trap_ready` high. In the following cycle `done` is high and `trap_ready` is low. One cycle later `done` is low and `trap_ready` is high again.
- R2: The supervisor level handles the trap when all three hold: the current privilege is user (0) or supervisor (1), the effective cause is below 32, and the bit of `ideleg` (for interrupts) or `edeleg` (for exceptions) indexed by that cause is set. Every other trap goes to the machine level (3).
- R3: `st_out` packs `{mpp[1:0], mpie, mie, spp, spie, sie}` from bit 6 down to bit 0, and `cur_status` uses the same layout. For the target level: previous-enable takes the current enable, previous-privilege takes the current privilege, and the enable is cleared. The other level's fields pass through unchanged.
- R4: The target level's cause register holds the effective cause zero-extended, with bit 31 set exactly when the trap is asynchronous.
- R5: The target level's return-address register takes `cur_pc`. The other level's cause, return-address and trap-value registers keep their values.
- R6: `next_pc` is the target vector base with bits 1:0 cleared. When the trap is asynchronous and the base's low two bits equal 01, cause×4 is added to it.
- R7: The trap value takes `trap_addr` for synchronous causes 0, 1, 4, 5, 6, 7, 12, 13 and 15. For all other synchronous causes and for every interrupt it takes zero.
- R8: A synchronous cause 8 is replaced before delegation by 8 from user, 9 from supervisor and 11 from machine privilege.
- R9: `next_priv` becomes 1 for a supervisor-level trap and 3 for a machine-level trap.
- R10: `flt_code` is 12/13/15 (fetch/load/store) when `flt_xlat_on` is high and `flt_prot` is low, and 1/5/7 otherwise. `flt_kind` encodes 0 = fetch, 1 = load, and 2 or 3 = store.
- R11: After reset, `done` is 0, `trap_ready` is 1, `next_priv` is 3, and all cause, return-address, trap-value, status and PC outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | Trap request valid |
| trap_ready | output | 1 | Unit can accept a request |
| trap_async | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause | input | 6 | Raw cause number |
| trap_addr | input | 32 | Faulting address |
| cur_pc | input | 32 | PC of the trapping instruction |
| cur_priv | input | 2 | Current privilege (0, 1, 3) |
| cur_status | input | 7 | Current status bits (layout in R3) |
| edeleg | input | 32 | Exception delegation mask |
| ideleg | input | 32 | Interrupt delegation mask |
| s_tvec | input | 32 | Supervisor vector base and mode |
| m_tvec | input | 32 | Machine vector base and mode |
| flt_kind | input | 2 | Access kind of a translation failure |
| flt_xlat_on | input | 1 | Translation was active |
| flt_prot | input | 1 | Failure was a protection violation |
| flt_code | output | 6 | Cause code for the translation failure |
| st_out | output | 7 | Committed status bits |
| s_cause | output | 32 | Supervisor cause register |
| s_epc | output | 32 | Supervisor return address |
| s_tval | output | 32 | Supervisor trap value |
| m_cause | output | 32 | Machine cause register |
| m_epc | output | 32 | Machine return address |
| m_tval | output | 32 | Machine trap value |
| next_pc | output | 32 | Handler address |
| next_priv | output | 2 | New privilege |
| to_s | output | 1 | Last trap went to supervisor level |
| done | output | 1 | One-cycle commit pulse |

## Verification
All registered results come from a single register stage. The request is driven at a falling edge and taken at the next rising edge. `done`, the status, cause, return-address, trap-value, PC and privilege outputs are then due in the cycle that follows that edge, and the bench reads them at the next falling edge. `trap_ready` is checked low at that same point, and `done` is checked low one cycle later. `flt_code` has no register, so it is read one time step after its inputs change.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef struct packed {
    logic [1:0] mpp;
    logic       mpie;
    logic       mie;
    logic       spp;
    logic       spie;
    logic       sie;
  } stat_t;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_t;

  localparam int C_FETCH_MIS  = 0;
  localparam int C_FETCH_ACC  = 1;
  localparam int C_LOAD_MIS   = 4;
  localparam int C_LOAD_ACC   = 5;
  localparam int C_STORE_MIS  = 6;
  localparam int C_STORE_ACC  = 7;
  localparam int C_ECALL_BASE = 8;
  localparam int C_FETCH_PG   = 12;
  localparam int C_LOAD_PG    = 13;
  localparam int C_STORE_PG   = 15;

  function automatic logic addr_cause(input int c);
    case (c)
      C_FETCH_MIS, C_FETCH_ACC, C_LOAD_MIS, C_LOAD_ACC,
      C_STORE_MIS, C_STORE_ACC, C_FETCH_PG, C_LOAD_PG, C_STORE_PG:
        addr_cause = 1'b1;
      default: addr_cause = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/trap_route.sv
module trap_route
  import trap_seq_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input  logic               async_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [1:0]         priv_i,
  input  logic [XLEN-1:0]    edeleg_i,
  input  logic [XLEN-1:0]    ideleg_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               to_s_o,
  output logic               keep_addr_o
);
  localparam int IW = $clog2(XLEN);

  logic [XLEN-1:0] mask;
  logic            in_range;

  always_comb begin
    cause_o = cause_i;
    if (!async_i && int'(cause_i) == C_ECALL_BASE)
      cause_o = CAUSE_W'(C_ECALL_BASE) + CAUSE_W'(priv_i);
  end

  assign mask        = async_i ? ideleg_i : edeleg_i;
  assign in_range    = int'(cause_o) < XLEN;
  assign to_s_o      = (priv_i <= PRIV_S) && in_range && mask[cause_o[IW-1:0]];
  assign keep_addr_o = !async_i && addr_cause(int'(cause_o));
endmodule

// File: rtl/trap_vec.sv
module trap_vec #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input  logic [XLEN-1:0]    base_i,
  input  logic               async_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic [XLEN-1:0]    pc_o
);
  logic [XLEN-1:0] offs;

  assign offs = (async_i && base_i[1:0] == 2'b01) ? (XLEN'(cause_i) << 2) : '0;
  assign pc_o = {base_i[XLEN-1:2], 2'b00} + offs;
endmodule

// File: rtl/fault_map.sv
module fault_map
  import trap_seq_pkg::*;
#(
  parameter int CAUSE_W = 6
) (
  input  logic [1:0]         kind_i,
  input  logic               xlat_on_i,
  input  logic               prot_i,
  output logic [CAUSE_W-1:0] code_o
);
  logic page;

  assign page = xlat_on_i && !prot_i;

  always_comb begin
    case (acc_t'(kind_i))
      ACC_FETCH: code_o = CAUSE_W'(page ? C_FETCH_PG : C_FETCH_ACC);
      ACC_LOAD:  code_o = CAUSE_W'(page ? C_LOAD_PG  : C_LOAD_ACC);
      default:   code_o = CAUSE_W'(page ? C_STORE_PG : C_STORE_ACC);
    endcase
  end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_seq_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_valid,
  output logic               trap_ready,
  input  logic               trap_async,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [XLEN-1:0]    trap_addr,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic [1:0]         cur_priv,
  input  logic [6:0]         cur_status,
  input  logic [XLEN-1:0]    edeleg,
  input  logic [XLEN-1:0]    ideleg,
  input  logic [XLEN-1:0]    s_tvec,
  input  logic [XLEN-1:0]    m_tvec,
  input  logic [1:0]         flt_kind,
  input  logic               flt_xlat_on,
  input  logic               flt_prot,
  output logic [CAUSE_W-1:0] flt_code,
  output logic [6:0]         st_out,
  output logic [XLEN-1:0]    s_cause,
  output logic [XLEN-1:0]    s_epc,
  output logic [XLEN-1:0]    s_tval,
  output logic [XLEN-1:0]    m_cause,
  output logic [XLEN-1:0]    m_epc,
  output logic [XLEN-1:0]    m_tval,
  output logic [XLEN-1:0]    next_pc,
  output logic [1:0]         next_priv,
  output logic               to_s,
  output logic               done
);
  localparam int NLVL = 2;

  logic               take;
  logic [CAUSE_W-1:0] eff_cause;
  logic               sel_s;
  logic               keep_addr;
  logic [XLEN-1:0]    cause_val;
  logic [XLEN-1:0]    tval_val;
  stat_t              st_in, st_nx, st_q;
  logic [XLEN-1:0]    vec_pc [NLVL];
  logic [XLEN-1:0]    cause_q [NLVL];
  logic [XLEN-1:0]    epc_q [NLVL];
  logic [XLEN-1:0]    tval_q [NLVL];
  logic [XLEN-1:0]    pc_q;
  logic [1:0]         priv_q;
  logic               to_s_q, done_q;

  assign take = trap_valid && trap_ready;

  trap_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_route (
    .async_i(trap_async), .cause_i(trap_cause), .priv_i(cur_priv),
    .edeleg_i(edeleg), .ideleg_i(ideleg),
    .cause_o(eff_cause), .to_s_o(sel_s), .keep_addr_o(keep_addr)
  );

  fault_map #(.CAUSE_W(CAUSE_W)) u_fmap (
    .kind_i(flt_kind), .xlat_on_i(flt_xlat_on), .prot_i(flt_prot), .code_o(flt_code)
  );

  assign cause_val = XLEN'(eff_cause) | (XLEN'(trap_async) << (XLEN - 1));
  assign tval_val  = keep_addr ? trap_addr : '0;
  assign st_in     = stat_t'(cur_status);

  always_comb begin
    st_nx = st_in;
    if (sel_s) begin
      st_nx.spie = st_in.sie;
      st_nx.spp  = cur_priv[0];
      st_nx.sie  = 1'b0;
    end else begin
      st_nx.mpie = st_in.mie;
      st_nx.mpp  = cur_priv;
      st_nx.mie  = 1'b0;
    end
  end

  // Level 0 = supervisor bank, level 1 = machine bank
  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    logic hit;
    assign hit = take && (sel_s == (g == 0));

    trap_vec #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vec (
      .base_i((g == 0) ? s_tvec : m_tvec), .async_i(trap_async),
      .cause_i(eff_cause), .pc_o(vec_pc[g])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cause_q[g] <= '0;
        epc_q[g]   <= '0;
        tval_q[g]  <= '0;
      end else if (hit) begin
        cause_q[g] <= cause_val;
        epc_q[g]   <= cur_pc;
        tval_q[g]  <= tval_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= '0;
      pc_q   <= '0;
      priv_q <= PRIV_M;
      to_s_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= take;
      if (take) begin
        st_q   <= st_nx;
        pc_q   <= sel_s ? vec_pc[0] : vec_pc[1];
        priv_q <= sel_s ? PRIV_S : PRIV_M;
        to_s_q <= sel_s;
      end
    end
  end

  assign trap_ready = !done_q;
  assign done       = done_q;
  assign st_out     = st_q;
  assign next_pc    = pc_q;
  assign next_priv  = priv_q;
  assign to_s       = to_s_q;
  assign s_cause    = cause_q[0];
  assign s_epc      = epc_q[0];
  assign s_tval     = tval_q[0];
  assign m_cause    = cause_q[1];
  assign m_epc      = epc_q[1];
  assign m_tval     = tval_q[1];

  p_done_after_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_ready) |=> (done && !trap_ready));
  p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_s_only_low_priv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_ready && cur_priv == PRIV_M) |=> !to_s);
  p_enable_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (to_s ? !st_out[0] : !st_out[3]));
  p_mepc_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !to_s) |-> m_epc == $past(cur_pc));
  p_sepc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && to_s) |-> $stable(s_epc));
  p_priv_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> next_priv == (to_s ? PRIV_S : PRIV_M));
endmodule

// File: tb/test_trap_entry_seq.sv
module test_trap_entry_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_valid = 1'b0;
  logic        trap_ready;
  logic        trap_async = 1'b0;
  logic [5:0]  trap_cause = '0;
  logic [31:0] trap_addr = '0;
  logic [31:0] cur_pc = '0;
  logic [1:0]  cur_priv = '0;
  logic [6:0]  cur_status = '0;
  logic [31:0] edeleg = (32'h1 << 5) | (32'h1 << 9);
  logic [31:0] ideleg = 32'h1 << 9;
  logic [31:0] s_tvec = 32'h0000_1001;
  logic [31:0] m_tvec = 32'h0000_2002;
  logic [1:0]  flt_kind = '0;
  logic        flt_xlat_on = 1'b0;
  logic        flt_prot = 1'b0;
  logic [5:0]  flt_code;
  logic [6:0]  st_out;
  logic [31:0] s_cause, s_epc, s_tval, m_cause, m_epc, m_tval, next_pc;
  logic [1:0]  next_priv;
  logic        to_s, done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  trap_entry_seq i_trap_entry_seq (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_ready(trap_ready),
    .trap_async(trap_async), .trap_cause(trap_cause), .trap_addr(trap_addr),
    .cur_pc(cur_pc), .cur_priv(cur_priv), .cur_status(cur_status),
    .edeleg(edeleg), .ideleg(ideleg), .s_tvec(s_tvec), .m_tvec(m_tvec),
    .flt_kind(flt_kind), .flt_xlat_on(flt_xlat_on), .flt_prot(flt_prot),
    .flt_code(flt_code), .st_out(st_out), .s_cause(s_cause), .s_epc(s_epc),
    .s_tval(s_tval), .m_cause(m_cause), .m_epc(m_epc), .m_tval(m_tval),
    .next_pc(next_pc), .next_priv(next_priv), .to_s(to_s), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic fire(input logic as, input logic [5:0] c, input logic [31:0] a,
                      input logic [31:0] pc, input logic [1:0] pv, input logic [6:0] st);
    @(negedge clk);
    trap_async = as; trap_cause = c; trap_addr = a;
    cur_pc = pc; cur_priv = pv; cur_status = st; trap_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    trap_valid = 1'b0;
    chk("R1 done", {31'b0, done}, 32'd1);
    chk("R1 ready low", {31'b0, trap_ready}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R11 done", {31'b0, done}, 32'd0);
    chk("R11 ready", {31'b0, trap_ready}, 32'd1);
    chk("R11 priv", {30'b0, next_priv}, 32'd3);
    chk("R11 m_cause", m_cause, 32'd0);
    chk("R11 s_epc", s_epc, 32'd0);
    chk("R11 status", {25'b0, st_out}, 32'd0);
  endtask

  task automatic t_s_exception;
    fire(1'b0, 6'd5, 32'h000D_EAD0, 32'h400, 2'd0, 7'h01);
    chk("R2 to_s", {31'b0, to_s}, 32'd1);
    chk("R3 status", {25'b0, st_out}, 32'h02);
    chk("R4 s_cause", s_cause, 32'd5);
    chk("R5 s_epc", s_epc, 32'h400);
    chk("R5 m_epc kept", m_epc, 32'd0);
    chk("R7 s_tval", s_tval, 32'h000D_EAD0);
    chk("R6 sync no vector", next_pc, 32'h1000);
    chk("R9 priv", {30'b0, next_priv}, 32'd1);
    @(negedge clk);
    chk("R1 done one cycle", {31'b0, done}, 32'd0);
    chk("R1 ready back", {31'b0, trap_ready}, 32'd1);
  endtask

  task automatic t_m_from_m;
    fire(1'b0, 6'd5, 32'h000B_EEF0, 32'h500, 2'd3, 7'h08);
    chk("R2 M priv not delegated", {31'b0, to_s}, 32'd0);
    chk("R3 status", {25'b0, st_out}, 32'h70);
    chk("R4 m_cause", m_cause, 32'd5);
    chk("R5 m_epc", m_epc, 32'h500);
    chk("R5 s_epc kept", s_epc, 32'h400);
    chk("R7 m_tval", m_tval, 32'h000B_EEF0);
    chk("R6 m base", next_pc, 32'h2000);
    chk("R9 priv", {30'b0, next_priv}, 32'd3);
  endtask

  task automatic t_s_interrupt;
    fire(1'b1, 6'd9, 32'h123, 32'h600, 2'd1, 7'h02);
    chk("R2 to_s", {31'b0, to_s}, 32'd1);
    chk("R3 status", {25'b0, st_out}, 32'h04);
    chk("R4 async msb", s_cause, 32'h8000_0009);
    chk("R7 irq tval zero", s_tval, 32'd0);
    chk("R6 vectored", next_pc, 32'h1024);
  endtask

  task automatic t_m_interrupt;
    fire(1'b1, 6'd7, 32'h0, 32'h700, 2'd0, 7'h01);
    chk("R2 not delegated", {31'b0, to_s}, 32'd0);
    chk("R3 s fields pass", {25'b0, st_out}, 32'h01);
    chk("R4 m_cause", m_cause, 32'h8000_0007);
    chk("R6 mode 2 not vectored", next_pc, 32'h2000);
    chk("R5 s_cause kept", s_cause, 32'h8000_0009);
    fire(1'b1, 6'd5, 32'h999, 32'h780, 2'd0, 7'h00);
    chk("R2 irq uses ideleg", {31'b0, to_s}, 32'd0);
    chk("R7 irq cause 5 tval zero", m_tval, 32'd0);
  endtask

  task automatic t_ecall;
    fire(1'b0, 6'd8, 32'h55, 32'h800, 2'd1, 7'h00);
    chk("R8 ecall S", s_cause, 32'd9);
    chk("R8 ecall S delegated", {31'b0, to_s}, 32'd1);
    chk("R7 ecall tval", s_tval, 32'd0);
    chk("R3 spp", {25'b0, st_out}, 32'h04);
    fire(1'b0, 6'd8, 32'h55, 32'h840, 2'd3, 7'h00);
    chk("R8 ecall M", m_cause, 32'd11);
    chk("R3 mpp", {25'b0, st_out}, 32'h60);
    fire(1'b0, 6'd8, 32'h55, 32'h880, 2'd0, 7'h00);
    chk("R8 ecall U", m_cause, 32'd8);
    chk("R2 ecall U not delegated", {31'b0, to_s}, 32'd0);
  endtask

  task automatic t_range_and_page;
    edeleg = '1;
    fire(1'b0, 6'd40, 32'hAAAA, 32'h900, 2'd0, 7'h00);
    chk("R2 cause 40 to M", {31'b0, to_s}, 32'd0);
    chk("R4 cause 40", m_cause, 32'd40);
    chk("R7 cause 40 tval", m_tval, 32'd0);
    edeleg = (32'h1 << 5) | (32'h1 << 9);
    fire(1'b0, 6'd13, 32'h7777_0000, 32'hA00, 2'd0, 7'h00);
    chk("R7 page fault tval", m_tval, 32'h7777_0000);
    chk("R5 m_epc", m_epc, 32'hA00);
  endtask

  task automatic t_fault_map;
    for (int k = 0; k < 4; k++) begin
      for (int m = 0; m < 3; m++) begin
        logic [5:0] e;
        flt_kind = 2'(k);
        flt_xlat_on = (m != 0);
        flt_prot = (m == 2);
        #1;
        case (k)
          0: e = (m == 1) ? 6'd12 : 6'd1;
          1: e = (m == 1) ? 6'd13 : 6'd5;
          default: e = (m == 1) ? 6'd15 : 6'd7;
        endcase
        chk("R10 fault code", {26'b0, flt_code}, {26'b0, e});
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_s_exception();
    t_m_from_m();
    t_s_interrupt();
    t_m_interrupt();
    t_ecall();
    t_range_and_page();
    t_fault_map();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule